// File: doc/BRIEF.md
# Gaussian Transmit Pulse Shaper

This block turns a one-bit transmit stream into a signed frequency-deviation word for a modulation DAC. The stream is sampled once per filter clock, and the filter clock runs at six times the bit rate. Each sample is mapped to +1 or -1 and pushed into a six-sample history. A symmetric six-tap Gaussian FIR, with bandwidth-time product 0.5 and spanning one symbol, smooths the history. The shaper then applies one of eight deviation scales and saturates the result to the output width.

The shaping only runs while both the shaping enable and the transmit-mode qualifier are high. In any other case the output is the unshaped full-scale level of the newest captured sample. The history keeps shifting in both modes. The driver of the stream must hold each data bit for six filter clocks and must meet the setup and hold window around the filter clock edge.

Top module: `gauss_shaper`

## Requirements
- R1: While reset is low, `dev_o` is 0. Reset fills the history with six 0 samples, and each of them counts as -1.
- R2: On every rising edge the shaper captures `tx_bit_i` as the newest sample. A 1 counts as +1 and a 0 counts as -1. When shaping is active at edge k, the filter sum is 20·s0 + 44·s1 + 64·s2 + 64·s3 + 44·s4 + 20·s5. Here s0 is the sample captured at edge k-1 and s5 is the sample captured at edge k-6. The scaled sum appears on `dev_o` after edge k.
- R3: `scale_code_i` values 0 to 7 select deviation steps of 60 % to 130 % in 10 % increments. The shaped output is floor((sum·(code+6)·5 + 4) / 8). With code 4 and six equal samples the output is +1600 or -1600.
- R4: The output is clamped to the range -2047 to +2047 and never takes the value -2048. Six 1 samples at code 7 give +2047, and six 0 samples at code 7 give -2047.
- R5: With `shape_en_i` low at edge k, `dev_o` after edge k is +2047 when the sample captured at edge k-1 was 1, and -2047 when it was 0.
- R6: With `tx_mode_i` low, the output follows the R5 rule even when `shape_en_i` is high.
- R7: In the unshaped path of R5 and R6, `scale_code_i` has no effect on `dev_o`.
- R8: The history keeps shifting while the output is unshaped. The first shaped output after re-enabling uses the six most recent samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Filter clock, six cycles per data bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_bit_i | input | 1 | Serial transmit data |
| shape_en_i | input | 1 | Shaping enable |
| tx_mode_i | input | 1 | High while the device is transmitting |
| scale_code_i | input | 3 | Deviation scale code, 60 % + 10 % per step |
| dev_o | output | 12 | Signed deviation command, two's complement |

## Verification
The properties assume that every input is settled at each rising clock edge, as the setup and hold window requires. They also assume that reset is asserted once at the start, so the history and the checker's run counters start from a known state. The sign properties rely only on six equal samples in a row, so they also hold for streams whose bits last fewer than six clocks. The stimulus drives every input on the falling edge and holds it for a whole cycle. It includes bit runs of many lengths, changes the scale code and the enables in the middle of a bit, and sends runs long enough to reach saturation at the top scale step.

// File: rtl/gshape_pkg.sv
`timescale 1ns/1ps
package gshape_pkg;

    localparam int TAPS   = 6;
    localparam int COEF_W = 8;
    localparam int SUM_W  = COEF_W + $clog2(TAPS) + 1;

    typedef enum logic {
        PATH_RAW    = 1'b0,
        PATH_SHAPED = 1'b1
    } path_e;

    // Gaussian taps, BT = 0.5, one symbol at six points, scaled to a sum of 256
    function automatic logic signed [COEF_W-1:0] tap_coef(input int k);
        case (k)
            0, 5:    return COEF_W'(20);
            1, 4:    return COEF_W'(44);
            default: return COEF_W'(64);
        endcase
    endfunction

endpackage

// File: rtl/gshape_delay.sv
`timescale 1ns/1ps
module gshape_delay #(
    parameter int TAPS = 6
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            bit_i,
    output logic [TAPS-1:0] hist_o
);

    logic [TAPS-1:0] hist_d, hist_q;

    always_comb begin
        hist_d = {hist_q[TAPS-2:0], bit_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '0;
        else         hist_q <= hist_d;
    end

    assign hist_o = hist_q;

endmodule

// File: rtl/gshape_fir.sv
`timescale 1ns/1ps
module gshape_fir
    import gshape_pkg::*;
#(
    parameter int N_TAP = TAPS,
    parameter int ACC_W = SUM_W
) (
    input  logic [N_TAP-1:0]        hist_i,
    output logic signed [ACC_W-1:0] sum_o
);

    logic signed [ACC_W-1:0] term [N_TAP];

    for (genvar k = 0; k < N_TAP; k++) begin : g_tap
        localparam logic signed [ACC_W-1:0] CK = ACC_W'(tap_coef(k));
        assign term[k] = hist_i[k] ? CK : -CK;
    end

    always_comb begin
        sum_o = '0;
        for (int k = 0; k < N_TAP; k++) begin
            sum_o = sum_o + term[k];
        end
    end

endmodule

// File: rtl/gshape_scale.sv
`timescale 1ns/1ps
module gshape_scale #(
    parameter int ACC_W     = 12,
    parameter int OUT_W     = 12,
    parameter int CODE_W    = 3,
    parameter int STEP_BASE = 6,
    parameter int GAIN      = 5,
    parameter int SHIFT     = 3
) (
    input  logic signed [ACC_W-1:0] sum_i,
    input  logic [CODE_W-1:0]       code_i,
    output logic signed [OUT_W-1:0] dev_o
);

    localparam int MAXV = 2**(OUT_W-1) - 1;
    localparam int HALF = (SHIFT > 0) ? 2**(SHIFT-1) : 0;

    int s_x, step_x, w_x;

    always_comb begin
        s_x    = int'(sum_i);
        step_x = int'(code_i) + STEP_BASE;
        w_x    = (s_x * step_x * GAIN + HALF) >>> SHIFT;
        if (w_x > MAXV)       dev_o = OUT_W'(MAXV);
        else if (w_x < -MAXV) dev_o = OUT_W'(-MAXV);
        else                  dev_o = w_x[OUT_W-1:0];
    end

endmodule

// File: rtl/gauss_shaper.sv
`timescale 1ns/1ps
module gauss_shaper
    import gshape_pkg::*;
#(
    parameter int OUT_W  = 12,
    parameter int CODE_W = 3,
    parameter int GAIN   = 5,
    parameter int SHIFT  = 3
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    tx_bit_i,
    input  logic                    shape_en_i,
    input  logic                    tx_mode_i,
    input  logic [CODE_W-1:0]       scale_code_i,
    output logic signed [OUT_W-1:0] dev_o
);

    localparam logic signed [OUT_W-1:0] FULL = {1'b0, {(OUT_W-1){1'b1}}};

    typedef struct packed {
        logic signed [OUT_W-1:0] dev;
    } st_t;

    st_t st_d, st_q;
    path_e path;
    logic [TAPS-1:0] hist;
    logic signed [SUM_W-1:0] fir_sum;
    logic signed [OUT_W-1:0] scaled;

    gshape_delay #(.TAPS(TAPS)) u_delay (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .bit_i  (tx_bit_i),
        .hist_o (hist)
    );

    gshape_fir #(.N_TAP(TAPS), .ACC_W(SUM_W)) u_fir (
        .hist_i (hist),
        .sum_o  (fir_sum)
    );

    gshape_scale #(
        .ACC_W     (SUM_W),
        .OUT_W     (OUT_W),
        .CODE_W    (CODE_W),
        .STEP_BASE (6),
        .GAIN      (GAIN),
        .SHIFT     (SHIFT)
    ) u_scale (
        .sum_i  (fir_sum),
        .code_i (scale_code_i),
        .dev_o  (scaled)
    );

    always_comb begin
        st_d = st_q;
        path = (shape_en_i && tx_mode_i) ? PATH_SHAPED : PATH_RAW;
        case (path)
            PATH_SHAPED: st_d.dev = scaled;
            default:     st_d.dev = hist[0] ? FULL : -FULL;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign dev_o = st_q.dev;

endmodule

// File: rtl/gshape_chk.sv
`timescale 1ns/1ps
module gshape_chk #(
    parameter int OUT_W = 12
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic                    tx_bit_i,
    input logic                    shape_en_i,
    input logic                    tx_mode_i,
    input logic signed [OUT_W-1:0] dev_o
);

    localparam logic signed [OUT_W-1:0] FULL = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic signed [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

    logic       up_q;
    logic [2:0] one_run_q, zero_run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            up_q       <= 1'b0;
            one_run_q  <= '0;
            zero_run_q <= '0;
        end else begin
            up_q       <= 1'b1;
            one_run_q  <= tx_bit_i ? ((one_run_q == 3'd7) ? 3'd7 : one_run_q + 3'd1) : 3'd0;
            zero_run_q <= !tx_bit_i ? ((zero_run_q == 3'd7) ? 3'd7 : zero_run_q + 3'd1) : 3'd0;
        end
    end

    // R1
    always @(posedge clk_i) begin
        if (!rst_ni) begin
            reset_zero_chk: assert (dev_o == '0);
        end
    end

    // R4
    dev_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dev_o != MOST_NEG);

    // R5
    raw_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        up_q && !(shape_en_i && tx_mode_i) && $past(tx_bit_i) |=> dev_o == FULL);

    // R6
    raw_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        up_q && !(shape_en_i && tx_mode_i) && !$past(tx_bit_i) |=> dev_o == -FULL);

    // R2
    shaped_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        one_run_q >= 3'd6 && shape_en_i && tx_mode_i |=> dev_o > 0);

    // R2
    shaped_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        zero_run_q >= 3'd6 && shape_en_i && tx_mode_i |=> dev_o < 0);

endmodule

bind gauss_shaper gshape_chk #(.OUT_W(OUT_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_bit_i   (tx_bit_i),
    .shape_en_i (shape_en_i),
    .tx_mode_i  (tx_mode_i),
    .dev_o      (dev_o)
);

// File: tb/sim_gauss_shaper.sv
`timescale 1ns/1ps
module sim_gauss_shaper;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tx_bit = 1'b0;
    logic              en = 1'b0;
    logic              md = 1'b0;
    logic [2:0]        code = 3'd0;
    logic signed [11:0] dev;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    string tag_q[$];
    logic [5:0] mh = 6'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gauss_shaper u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .tx_bit_i     (tx_bit),
        .shape_en_i   (en),
        .tx_mode_i    (md),
        .scale_code_i (code),
        .dev_o        (dev)
    );

    // R2 coefficients, R3 formula, R4 clamp, R5/R6 raw level
    function automatic int model(input logic [5:0] h, input logic e, input logic m, input int c);
        int cf[6] = '{20, 44, 64, 64, 44, 20};
        int s = 0;
        int v;
        if (!e || !m) return h[0] ? 2047 : -2047;
        for (int k = 0; k < 6; k++) s += h[k] ? cf[k] : -cf[k];
        v = (s * (c + 6) * 5 + 4) >>> 3;
        if (v > 2047) v = 2047;
        if (v < -2047) v = -2047;
        return v;
    endfunction

    task automatic step(input logic b, input logic e, input logic m, input int c, input string tag);
        tx_bit = b; en = e; md = m; code = c[2:0];
        exp_q.push_back(model(mh, e, m, c));
        tag_q.push_back(tag);
        mh = {mh[4:0], b};
        @(negedge clk);
    endtask

    task automatic hold(input logic b, input logic e, input logic m, input int c, input int n, input string tag);
        for (int i = 0; i < n; i++) step(b, e, m, c, tag);
    endtask

    task automatic direct(input int act, input int expv, input string tag);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: dev=%0d expected %0d", tag, act, expv);
        end
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            direct(int'(dev), e, t);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int pat[8] = '{1, 0, 1, 1, 0, 0, 1, 0};
        repeat (3) @(negedge clk);
        direct(int'(dev), 0, "R1 reset value");
        rst_n = 1'b1;
        // R1: cleared history counts as six -1 samples
        step(1'b1, 1'b1, 1'b1, 4, "R1 first output after reset");
        hold(1'b1, 1'b1, 1'b1, 4, 11, "R2 rising run");
        hold(1'b0, 1'b1, 1'b1, 4, 12, "R2 falling run");
        // R3: mixed bits, six clocks each, all scale codes
        for (int i = 0; i < 16; i++) hold(pat[i % 8][0], 1'b1, 1'b1, i % 8, 6, "R3 scaled shape");
        // R2: short bits and a code change inside a bit
        for (int i = 0; i < 12; i++) step(i[1], 1'b1, 1'b1, 2, "R2 short bits");
        hold(1'b1, 1'b1, 1'b1, 7, 3, "R3 code change mid bit");
        hold(1'b1, 1'b1, 1'b1, 1, 3, "R3 code change mid bit");
        // R4: saturation at top step
        hold(1'b1, 1'b1, 1'b1, 7, 10, "R4 positive clamp");
        hold(1'b0, 1'b1, 1'b1, 7, 10, "R4 negative clamp");
        hold(1'b1, 1'b1, 1'b1, 6, 8, "R4 below clamp");
        // R5/R7: enable low, varying code
        for (int i = 0; i < 16; i++) step(i[2], 1'b0, 1'b1, i % 8, "R5 R7 raw with enable low");
        // R8: re-enable after raw period
        hold(1'b1, 1'b0, 1'b1, 3, 3, "R8 history during raw");
        hold(1'b0, 1'b0, 1'b1, 3, 2, "R8 history during raw");
        hold(1'b0, 1'b1, 1'b1, 3, 6, "R8 reenable");
        // R6/R7: tx mode low with enable high
        for (int i = 0; i < 16; i++) step(i[1] ^ i[3], 1'b1, 1'b0, 7 - (i % 8), "R6 R7 raw with tx mode low");
        hold(1'b1, 1'b1, 1'b1, 5, 8, "R8 reenable after mode low");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule